// File: doc/BRIEF.md
# Four-Slot Alarm Match Unit

This block keeps four independent alarm settings. Each one holds an hour, a minute and a morning/afternoon flag. Every cycle it compares each setting with the running time of day. When a setting starts to agree with that time, and its slot is switched on, the slot raises a match flag. The flag stays up until a snooze strobe clears all flags at once. A slot that is still switched on fires again the next time its time comes round.

Settings are written through a shared data bus. A per-slot load strobe picks which slots take the data. A per-slot toggle strobe flips the stored morning/afternoon flag of a slot while it is being edited. An enable switch bank turns the slots on and off, and a registered copy of the switches is reported back for status lamps. Every pin is a plain control or status level. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `alarm_bank`

## Requirements
- R1: While `rst_n` is low, every match flag and enable status bit is 0. Every stored setting returns to hour 0, minute 0, morning (pm flag 0).
- R2: `enable_o[i]` shows `sw_enable[i]` as it was at the previous rising clock edge.
- R3: On an edge where `ld_slot[i]` is 1, slot i stores `ld_hour`, `ld_min` and `ld_pm`. Slots whose load bit is 0 keep their setting.
- R4: On an edge where `pm_toggle[i]` is 1 and `ld_slot[i]` is 0, slot i inverts its stored pm flag. When both are 1, the load wins.
- R5: A slot is "equal" in a cycle when its registered enable is 1 and `cur_hour`, `cur_min` and `cur_pm` all equal its stored values. On the first equal cycle after a non-equal one, `match_o[i]` goes to 1 at the next edge.
- R6: Once set, `match_o[i]` stays at 1 until a snooze edge.
- R7: A snooze edge clears every match flag. Snooze wins over a match that begins on the same edge.
- R8: A slot whose registered enable is 0 never sets its match flag. A flag that is already set is kept.
- R9: While a slot stays equal without a break, it does not fire again after a snooze. Once equality ends, the slot re-arms and fires at the next start of equality.
- R10: The pm flag takes part in the comparison. A setting that differs from the current time only in pm never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_hour | input | 4 | Current hour |
| cur_min | input | 6 | Current minute |
| cur_pm | input | 1 | Current afternoon flag |
| ld_slot | input | 4 | Per-slot load strobe |
| ld_hour | input | 4 | Hour to store |
| ld_min | input | 6 | Minute to store |
| ld_pm | input | 1 | Afternoon flag to store |
| pm_toggle | input | 4 | Per-slot stored-pm invert strobe |
| sw_enable | input | 4 | Per-slot enable switches |
| snooze | input | 1 | Clear-all-matches strobe |
| match_o | output | 4 | Latched match flag per slot |
| enable_o | output | 4 | Registered enable status per slot |

## Verification
The bench goes after snooze held inside a still-matching minute. A level-triggered design would raise the flag again at once, while the required design stays clear until the time leaves and comes back. It drives snooze on the same edge that equality begins, where a design that let the set win would leave a flag standing. It also covers settings that differ from the current time only in pm, which a comparator without the flag would wrongly fire on. Finally it applies toggle and load together on one slot, where the wrong priority would store the inverted flag. Random loads, toggles, switch changes and snoozes over a narrow time range keep hits frequent, and a bench model checks each cycle.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int HOUR_W = 4;
  localparam int MIN_W  = 6;

  typedef struct packed {
    logic              pm;
    logic [HOUR_W-1:0] hr;
    logic [MIN_W-1:0]  mn;
  } alarm_time_t;

  localparam alarm_time_t TIME_ZERO = '{pm: 1'b0, hr: '0, mn: '0};
endpackage

// File: rtl/alarm_time_cmp.sv
module alarm_time_cmp
  import alarm_pkg::*;
(
  input  alarm_time_t now_t,
  input  alarm_time_t set_t,
  input  logic        armed,
  output logic        hit
);
  logic same_hr, same_mn, same_pm;

  always_comb begin
    same_hr = (now_t.hr == set_t.hr);
    same_mn = (now_t.mn == set_t.mn);
    same_pm = (now_t.pm == set_t.pm);
    hit     = armed & same_hr & same_mn & same_pm;
  end
endmodule

// File: rtl/alarm_slot.sv
module alarm_slot
  import alarm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_en,
  input  logic        ld,
  input  alarm_time_t ld_time,
  input  logic        pm_tog,
  input  alarm_time_t now_t,
  input  logic        snooze,
  output logic        match,
  output logic        en_stat
);
  alarm_time_t stored_q;
  logic        en_q;
  logic        hit;
  logic        hit_q;
  logic        match_q;
  logic        hit_start;

  // Stored setting: load has priority over pm toggle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stored_q <= TIME_ZERO;
    end else if (ld) begin
      stored_q <= ld_time;
    end else if (pm_tog) begin
      stored_q.pm <= ~stored_q.pm;
    end
  end

  // R3
  load_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> stored_q == $past(ld_time));

  // R4
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_tog && !ld) |=> stored_q.pm != $past(stored_q.pm));

  // Registered enable switch
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= sw_en;
  end

  // R2
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> en_q == $past(sw_en));

  alarm_time_cmp u_cmp (
    .now_t (now_t),
    .set_t (stored_q),
    .armed (en_q),
    .hit   (hit)
  );

  // Edge detect on equality so a flag cleared mid-minute stays clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit;
  end

  assign hit_start = hit & ~hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         match_q <= 1'b0;
    else if (snooze)    match_q <= 1'b0;
    else if (hit_start) match_q <= 1'b1;
  end

  // R5
  match_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !hit_q && !snooze) |=> match_q);

  // R6
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_q && !snooze) |=> match_q);

  // R7
  snooze_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snooze |=> !match_q);

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !match_q) |=> !match_q);

  // R9
  no_refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !match_q) |=> !match_q);

  assign match   = match_q;
  assign en_stat = en_q;
endmodule

// File: rtl/alarm_bank.sv
module alarm_bank
  import alarm_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [HOUR_W-1:0]    cur_hour,
  input  logic [MIN_W-1:0]     cur_min,
  input  logic                 cur_pm,
  input  logic [NUM_SLOTS-1:0] ld_slot,
  input  logic [HOUR_W-1:0]    ld_hour,
  input  logic [MIN_W-1:0]     ld_min,
  input  logic                 ld_pm,
  input  logic [NUM_SLOTS-1:0] pm_toggle,
  input  logic [NUM_SLOTS-1:0] sw_enable,
  input  logic                 snooze,
  output logic [NUM_SLOTS-1:0] match_o,
  output logic [NUM_SLOTS-1:0] enable_o
);
  alarm_time_t now_t;
  alarm_time_t ld_time;

  always_comb begin
    now_t.pm   = cur_pm;
    now_t.hr   = cur_hour;
    now_t.mn   = cur_min;
    ld_time.pm = ld_pm;
    ld_time.hr = ld_hour;
    ld_time.mn = ld_min;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    alarm_slot u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .sw_en   (sw_enable[g]),
      .ld      (ld_slot[g]),
      .ld_time (ld_time),
      .pm_tog  (pm_toggle[g]),
      .now_t   (now_t),
      .snooze  (snooze),
      .match   (match_o[g]),
      .en_stat (enable_o[g])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (match_o == '0 && enable_o == '0));
endmodule

// File: tb/alarm_bank_tb.sv
module alarm_bank_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   cur_hour = '0;
  logic [5:0]   cur_min = '0;
  logic         cur_pm = 1'b0;
  logic [N-1:0] ld_slot = '0;
  logic [3:0]   ld_hour = '0;
  logic [5:0]   ld_min = '0;
  logic         ld_pm = 1'b0;
  logic [N-1:0] pm_toggle = '0;
  logic [N-1:0] sw_enable = '0;
  logic         snooze = 1'b0;
  logic [N-1:0] match_o;
  logic [N-1:0] enable_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  alarm_bank #(.NUM_SLOTS(N)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cur_hour(cur_hour), .cur_min(cur_min), .cur_pm(cur_pm),
    .ld_slot(ld_slot), .ld_hour(ld_hour), .ld_min(ld_min), .ld_pm(ld_pm),
    .pm_toggle(pm_toggle), .sw_enable(sw_enable), .snooze(snooze),
    .match_o(match_o), .enable_o(enable_o)
  );

  // Reference model built from the requirements
  logic [3:0]   m_hr [N];
  logic [5:0]   m_mn [N];
  logic         m_pm [N];
  logic [N-1:0] m_en, m_eqp, m_match;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_hr[i] <= '0; m_mn[i] <= '0; m_pm[i] <= 1'b0;
      end
      m_en <= '0; m_eqp <= '0; m_match <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        logic eq_v;
        eq_v = m_en[i] && cur_hour == m_hr[i] && cur_min == m_mn[i] && cur_pm == m_pm[i];
        m_eqp[i] <= eq_v;
        if (snooze)                m_match[i] <= 1'b0;
        else if (eq_v && !m_eqp[i]) m_match[i] <= 1'b1;
        if (ld_slot[i]) begin
          m_hr[i] <= ld_hour; m_mn[i] <= ld_min; m_pm[i] <= ld_pm;
        end else if (pm_toggle[i]) begin
          m_pm[i] <= ~m_pm[i];
        end
      end
      m_en <= sw_enable;
    end
  end

  task automatic chk(input logic [N-1:0] act, input logic [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk(match_o, m_match, {tag, " match"});
    chk(enable_o, m_en, "R2 enable status");
  endtask

  task automatic idle();
    ld_slot = '0; pm_toggle = '0; snooze = 1'b0;
  endtask

  task automatic set_now(input int h, input int m, input bit p);
    cur_hour = 4'(h); cur_min = 6'(m); cur_pm = p;
  endtask

  task automatic load(input logic [N-1:0] s, input int h, input int m, input bit p);
    ld_slot = s; ld_hour = 4'(h); ld_min = 6'(m); ld_pm = p;
    tick("R3 load");
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h5eed_a1a1;
    void'($urandom(seed));
    // R1: outputs cleared during reset
    set_now(7, 7, 1);
    repeat (2) @(negedge clk);
    chk(match_o, '0, "R1 reset match");
    chk(enable_o, '0, "R1 reset enable");
    rst_n = 1'b1;
    tick("R1");
    // R1: stored setting cleared to 0:00 morning, so it fires at that time
    set_now(0, 0, 0);
    sw_enable = 4'b0001;
    tick("R2");
    tick("R1 cleared setting");
    chk(match_o, 4'b0001, "R1 stored zero fires");
    snooze = 1'b1; tick("R7"); idle();
    chk(match_o, 4'b0000, "R7 snooze clears");
    // R9: still equal, no refire
    repeat (3) tick("R9 hold");
    chk(match_o, 4'b0000, "R9 no refire same minute");
    // R9 re-arm after time moves on and returns
    set_now(0, 1, 0); tick("R9");
    set_now(0, 0, 0); tick("R9");
    chk(match_o, 4'b0001, "R9 re-arm fires");
    // R6 held while time moves on
    set_now(5, 5, 0); repeat (3) tick("R6");
    chk(match_o, 4'b0001, "R6 flag held");
    snooze = 1'b1; tick("R7"); idle();
    // R10: pm differs only
    load(4'b0010, 11, 30, 1);
    sw_enable = 4'b0011;
    set_now(11, 30, 0); tick("R10"); tick("R10");
    chk(match_o, 4'b0000, "R10 pm mismatch quiet");
    // R4: toggle pm then it matches
    pm_toggle = 4'b0010; tick("R4"); idle(); tick("R4");
    chk(match_o, 4'b0010, "R4 toggled pm fires");
    snooze = 1'b1; tick("R7"); idle();
    // R4: load wins over toggle
    ld_slot = 4'b0100; pm_toggle = 4'b0100; ld_hour = 9; ld_min = 15; ld_pm = 1'b1;
    tick("R4 priority"); idle();
    sw_enable = 4'b0100; set_now(9, 15, 1); tick("R4"); tick("R4");
    chk(match_o, 4'b0100, "R4 load beats toggle");
    // R7: snooze on edge equality starts
    snooze = 1'b1; tick("R7"); idle();
    set_now(9, 16, 1); tick("R7");
    set_now(9, 15, 1); snooze = 1'b1; tick("R7 same edge"); idle();
    chk(match_o, 4'b0000, "R7 snooze wins over set");
    // R8: disabled slot quiet
    load(4'b1000, 3, 3, 0);
    sw_enable = 4'b0000; set_now(3, 3, 0); repeat (3) tick("R8");
    chk(match_o, 4'b0000, "R8 disabled never fires");
    // R5 random mixing
    for (int c = 0; c < 3000; c++) begin
      set_now($urandom_range(1, 2), $urandom_range(0, 2), 1'($urandom_range(0, 1)));
      ld_slot   = ($urandom_range(0, 7) == 0) ? 4'($urandom) : '0;
      ld_hour   = 4'($urandom_range(1, 2));
      ld_min    = 6'($urandom_range(0, 2));
      ld_pm     = 1'($urandom_range(0, 1));
      pm_toggle = ($urandom_range(0, 9) == 0) ? 4'($urandom) : '0;
      snooze    = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 5) == 0) sw_enable = 4'($urandom);
      tick("R5 random");
    end
    idle();
    finish_run();
  end
endmodule